// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Register

This block is the shift stage of an integer execution datapath. It takes a data word and moves its bits left or right by a count: logical left, logical right, arithmetic right, rotate right, or a single-place rotate right that passes through the carry flag, which makes the rotation one bit wider than the word. The result comes out combinationally in the same cycle as the inputs.

The count comes from one of two sources. One is a short immediate field. The other is a general register, of which only the low byte is used. Because a byte can hold counts far larger than the word width, every operation has a fixed result and carry for counts at and above the word width.

Alongside the result, the block forms the next negative, zero, carry and overflow flags from the flags the caller presents. It latches them in a register with a synchronous reset. When the set-flags enable is low, the presented flags are carried through unchanged.

Top module: `shift_carry_unit`

## Requirements
- R1: Opcode 0 is logical shift left. For a count n with 0 < n < 32, the result is operand << n and the carry is operand[32-n]. For n = 32, the result is zero and the carry is operand[0]. For n > 32, both the result and the carry are zero.
- R2: Opcode 1 is logical shift right. For 0 < n < 32, the result is operand >> n with zero fill and the carry is operand[n-1]. For n = 32, the result is zero and the carry is operand[31]. For n > 32, both are zero.
- R3: Opcode 2 is arithmetic shift right. For 0 < n < 32, bit 31 is replicated into the vacated bits and the carry is operand[n-1]. For n >= 32, every result bit and the carry equal operand[31].
- R4: Opcode 3 is rotate right by n mod 32, and the carry equals result bit 31. For a non-zero n that is a multiple of 32, the result equals the operand and the carry equals operand[31].
- R5: Opcode 4 is rotate right through carry. The result is {C_in, operand[31:1]} and the carry is operand[0]. The count is ignored.
- R6: With use_reg_i high, the count is reg_cnt_i[7:0] and bits [31:8] have no effect. With use_reg_i low, the count is the 5-bit imm_cnt_i.
- R7: For opcodes 0 to 3 with a count of zero, the result equals the operand and the carry keeps flags_i C.
- R8: The flag vectors are packed as {N,Z,C,V} in bits 3..0. With set_flags_i high, the registered N is result bit 31 and Z is 1 exactly when the result is zero.
- R9: With set_flags_i high, the registered C is the carry defined by R1 to R5 and R7, and V equals flags_i V.
- R10: With set_flags_i low, flags_o becomes flags_i on the next clock edge.
- R11: While rst_n is low at a rising clock edge, flags_o becomes 0000.
- R12: Opcodes 5 to 7 return the operand unchanged and keep flags_i C.
- R13: result_o follows the inputs in the same cycle, and flags_o follows them one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_i | input | 3 | Operation code |
| use_reg_i | input | 1 | Selects the register count (1) or the immediate count (0) |
| imm_cnt_i | input | 5 | Immediate count |
| reg_cnt_i | input | 32 | Register holding the count in its low byte |
| operand_i | input | 32 | Data word to shift |
| flags_i | input | 4 | Current {N,Z,C,V} |
| set_flags_i | input | 1 | Update the flags from this operation |
| result_o | output | 32 | Shifted or rotated word |
| flags_o | output | 4 | Registered next {N,Z,C,V} |

## Verification
The bench builds the block with its default widths: a 32-bit word, an 8-bit register count and a 5-bit immediate. With those widths, a register count can reach exactly 32 and every value up to 255. This covers the boundary at the word width, counts just past it, and rotate counts that are non-zero multiples of 32. The upper register bits are loaded with noise to show that they do not matter. Directed vectors cover each boundary. A long run of random vectors follows, compared each clock against a bit-at-a-time behavioural model.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_LSR = 3'd1,
        OP_ASR = 3'd2,
        OP_ROR = 3'd3,
        OP_RRX = 3'd4
    } shift_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/shift_amount_sel.sv
module shift_amount_sel #(
    parameter int CNT_W = 8,
    parameter int IMM_W = 5
) (
    input  logic             use_reg_i,
    input  logic [IMM_W-1:0] imm_cnt_i,
    input  logic [CNT_W-1:0] reg_cnt_lo_i,
    output logic [CNT_W-1:0] amt_o
);

    logic [CNT_W-1:0] imm_ext;

    // Fit the immediate field to the count width.
    generate
        if (IMM_W < CNT_W) begin : g_ext
            assign imm_ext = {{(CNT_W-IMM_W){1'b0}}, imm_cnt_i};
        end else begin : g_trunc
            assign imm_ext = imm_cnt_i[CNT_W-1:0];
        end
    endgenerate

    assign amt_o = use_reg_i ? reg_cnt_lo_i : imm_ext;

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [2:0]        op_i,
    input  logic [CNT_W-1:0]  amt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              c_in_i,
    output logic [DATA_W-1:0] result_o,
    output logic              c_out_o
);

    localparam int               LOG_W = $clog2(DATA_W);
    localparam int               WIDE  = 2 * DATA_W;
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(DATA_W);

    logic                     amt_zero;
    logic                     amt_eq;
    logic                     amt_big;
    logic                     in_range;
    logic [LOG_W-1:0]         amt_lo;
    logic [WIDE-1:0]          lsl_wide;
    logic [WIDE-1:0]          lsr_wide;
    logic signed [WIDE-1:0]   asr_src;
    logic [WIDE-1:0]          asr_wide;
    logic [WIDE-1:0]          rot_wide;
    logic                     sign;

    always_comb begin
        amt_zero = (amt_i == '0);
        amt_eq   = (amt_i == W_CNT);
        amt_big  = (amt_i > W_CNT);
        in_range = !amt_zero && !amt_eq && !amt_big;
        amt_lo   = amt_i[LOG_W-1:0];
        sign     = operand_i[DATA_W-1];

        // The bit just past the kept word is the last bit shifted out.
        lsl_wide = {{DATA_W{1'b0}}, operand_i} << amt_lo;
        lsr_wide = {operand_i, {DATA_W{1'b0}}} >> amt_lo;
        asr_src  = {operand_i, {DATA_W{1'b0}}};
        asr_wide = asr_src >>> amt_lo;
        rot_wide = {operand_i, operand_i} >> amt_lo;

        result_o = operand_i;
        c_out_o  = c_in_i;

        case (op_i)
            OP_LSL: begin
                if (in_range) begin
                    result_o = lsl_wide[DATA_W-1:0];
                    c_out_o  = lsl_wide[DATA_W];
                end else if (amt_eq) begin
                    result_o = '0;
                    c_out_o  = operand_i[0];
                end else if (amt_big) begin
                    result_o = '0;
                    c_out_o  = 1'b0;
                end
            end
            OP_LSR: begin
                if (in_range) begin
                    result_o = lsr_wide[WIDE-1:DATA_W];
                    c_out_o  = lsr_wide[DATA_W-1];
                end else if (amt_eq) begin
                    result_o = '0;
                    c_out_o  = sign;
                end else if (amt_big) begin
                    result_o = '0;
                    c_out_o  = 1'b0;
                end
            end
            OP_ASR: begin
                if (in_range) begin
                    result_o = asr_wide[WIDE-1:DATA_W];
                    c_out_o  = asr_wide[DATA_W-1];
                end else if (!amt_zero) begin
                    result_o = {DATA_W{sign}};
                    c_out_o  = sign;
                end
            end
            OP_ROR: begin
                if (!amt_zero) begin
                    result_o = rot_wide[DATA_W-1:0];
                    c_out_o  = rot_wide[DATA_W-1];
                end
            end
            OP_RRX: begin
                result_o = {c_in_i, operand_i[DATA_W-1:1]};
                c_out_o  = operand_i[0];
            end
            default: begin
                result_o = operand_i;
                c_out_o  = c_in_i;
            end
        endcase
    end

endmodule

// File: rtl/shift_flag_next.sv
module shift_flag_next
    import shift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              c_out_i,
    input  flags_t            flags_in_i,
    output flags_t            flags_next_o
);

    always_comb begin
        flags_next_o = flags_in_i;
        if (set_flags_i) begin
            flags_next_o.n = result_i[DATA_W-1];
            flags_next_o.z = ~|result_i;
            flags_next_o.c = c_out_i;
            flags_next_o.v = flags_in_i.v;
        end
    end

endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic              use_reg_i,
    input  logic [IMM_W-1:0]  imm_cnt_i,
    input  logic [DATA_W-1:0] reg_cnt_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [3:0]        flags_i,
    input  logic              set_flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o
);

    logic [CNT_W-1:0] amt;
    logic             c_out;
    logic             unused_cnt_hi;
    flags_t           flags_in;
    flags_t           flag_d;
    flags_t           flag_q;
    flags_t           flag_calc;

    // Upper register bits take no part in the count.
    assign unused_cnt_hi = ^reg_cnt_i[DATA_W-1:CNT_W];
    assign flags_in      = flags_t'(flags_i);

    shift_amount_sel #(
        .CNT_W (CNT_W),
        .IMM_W (IMM_W)
    ) u_amt (
        .use_reg_i    (use_reg_i),
        .imm_cnt_i    (imm_cnt_i),
        .reg_cnt_lo_i (reg_cnt_i[CNT_W-1:0]),
        .amt_o        (amt)
    );

    shift_datapath #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .op_i      (op_i),
        .amt_i     (amt),
        .operand_i (operand_i),
        .c_in_i    (flags_in.c),
        .result_o  (result_o),
        .c_out_o   (c_out)
    );

    shift_flag_next #(
        .DATA_W (DATA_W)
    ) u_flags (
        .set_flags_i  (set_flags_i),
        .result_i     (result_o),
        .c_out_i      (c_out),
        .flags_in_i   (flags_in),
        .flags_next_o (flag_calc)
    );

    always_comb begin
        flag_d = flag_calc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/shift_carry_unit_chk.sv
module shift_carry_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int IMM_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic              use_reg_i,
    input logic [IMM_W-1:0]  imm_cnt_i,
    input logic [CNT_W-1:0]  reg_cnt_lo,
    input logic [DATA_W-1:0] operand_i,
    input logic [3:0]        flags_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [3:0]        flags_o
);

    localparam int               LOG_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] W_CNT = CNT_W'(DATA_W);

    logic [CNT_W-1:0] eff;
    assign eff = use_reg_i ? reg_cnt_lo : CNT_W'(imm_cnt_i);

    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> flags_o == 4'b0000);

    p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> flags_o == $past(flags_i));

    p_neg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> flags_o[3] == $past(result_o[DATA_W-1]));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> flags_o[2] == ($past(result_o) == '0));

    p_v_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> flags_o[0] == $past(flags_i[0]));

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i < 3'd4 && eff == '0) |-> result_o == operand_i);

    p_zero_count_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && op_i < 3'd4 && eff == '0) |=> flags_o[1] == $past(flags_i[1]));

    p_lsl_far_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && eff > W_CNT) |-> result_o == '0);

    p_asr_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && eff >= W_CNT) |-> result_o == {DATA_W{operand_i[DATA_W-1]}});

    p_ror_full_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && eff != '0 && eff[LOG_W-1:0] == '0) |-> result_o == operand_i);

    p_rrx_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == 3'd4 |-> result_o == {flags_i[1], operand_i[DATA_W-1:1]});

    p_rrx_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && set_flags_i) |=> flags_o[1] == $past(operand_i[0]));

    p_reserved_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_i > 3'd4 |-> result_o == operand_i);

endmodule

bind shift_carry_unit shift_carry_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .IMM_W  (IMM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .use_reg_i   (use_reg_i),
    .imm_cnt_i   (imm_cnt_i),
    .reg_cnt_lo  (reg_cnt_i[CNT_W-1:0]),
    .operand_i   (operand_i),
    .flags_i     (flags_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .flags_o     (flags_o)
);

// File: tb/shift_carry_unit_bench.sv
`timescale 1ns/1ps
module shift_carry_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic        use_reg;
    logic [4:0]  imm;
    logic [31:0] rcnt;
    logic [31:0] opnd;
    logic [3:0]  fl_in;
    logic        sf;
    logic [31:0] result;
    logic [3:0]  fl_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    shift_carry_unit u_shift_carry_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op),
        .use_reg_i   (use_reg),
        .imm_cnt_i   (imm),
        .reg_cnt_i   (rcnt),
        .operand_i   (opnd),
        .flags_i     (fl_in),
        .set_flags_i (sf),
        .result_o    (result),
        .flags_o     (fl_out)
    );

    // Behavioural model: moves one bit per step, tracking the last bit out.
    task automatic model(input logic [2:0] o, input int n, input logic [31:0] a,
                         input logic cin, output logic [31:0] r, output logic c);
        r = a;
        c = cin;
        case (o)
            3'd0: for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
            3'd1: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
            3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
            3'd3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
            3'd4: begin c = a[0]; r = {cin, a[31:1]}; end
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R12";
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic vec(input logic [2:0] o, input bit ureg, input logic [4:0] im,
                       input logic [31:0] rc, input logic [31:0] a,
                       input logic [3:0] f, input bit s, input string tag);
        logic [31:0] er;
        logic        ec;
        logic [3:0]  ef;
        int          n;
        op = o; use_reg = ureg; imm = im; rcnt = rc; opnd = a; fl_in = f; sf = s;
        n = ureg ? int'(rc[7:0]) : int'(im);
        model(o, n, a, f[1], er, ec);
        #1;
        check(tag, "result R13", result, er);
        ef = s ? {er[31], (er == 32'd0), ec, f[0]} : f;
        @(negedge clk);
        check(s ? "R8 R9" : "R10", "flags", {28'd0, fl_out}, {28'd0, ef});
    endtask

    initial begin
        rst_n = 1'b0; op = 3'd0; use_reg = 1'b0; imm = 5'd0; rcnt = '0;
        opnd = 32'hFFFF_FFFF; fl_in = 4'hF; sf = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "reset flags", {28'd0, fl_out}, 32'd0);
        rst_n = 1'b1;

        vec(3'd0, 0, 5'd4,  '0,            32'h8000_000F, 4'h0, 1, "R1");
        vec(3'd0, 1, 5'd0,  32'd32,        32'h0000_0001, 4'h0, 1, "R1");
        vec(3'd0, 1, 5'd0,  32'd33,        32'hFFFF_FFFF, 4'h2, 1, "R1");
        vec(3'd0, 1, 5'd0,  32'hABCD_0003, 32'h6000_0001, 4'h0, 1, "R6");
        vec(3'd0, 1, 5'd0,  32'h1234_5620, 32'h0000_0001, 4'h0, 1, "R6");
        vec(3'd1, 1, 5'd0,  32'd32,        32'h8000_0000, 4'h0, 1, "R2");
        vec(3'd1, 1, 5'd0,  32'd40,        32'hFFFF_FFFF, 4'h2, 1, "R2");
        vec(3'd1, 0, 5'd31, 32'hFFFF_FF00, 32'hC000_0000, 4'h0, 1, "R6");
        vec(3'd2, 0, 5'd5,  '0,            32'h8000_0010, 4'h0, 1, "R3");
        vec(3'd2, 1, 5'd0,  32'd32,        32'h8000_0000, 4'h0, 1, "R3");
        vec(3'd2, 1, 5'd0,  32'd200,       32'h7FFF_FFFF, 4'h2, 1, "R3");
        vec(3'd3, 0, 5'd8,  '0,            32'h1234_5678, 4'h0, 1, "R4");
        vec(3'd3, 1, 5'd0,  32'd32,        32'h8765_4321, 4'h0, 1, "R4");
        vec(3'd3, 1, 5'd0,  32'd64,        32'h0765_4321, 4'h2, 1, "R4");
        vec(3'd3, 1, 5'd0,  32'd37,        32'h0000_0010, 4'h0, 1, "R4");
        vec(3'd4, 0, 5'd9,  '0,            32'h0000_0003, 4'h2, 1, "R5");
        vec(3'd4, 1, 5'd0,  32'd77,        32'h8000_0002, 4'h0, 1, "R5");
        vec(3'd0, 0, 5'd0,  '0,            32'h0000_0000, 4'h2, 1, "R7");
        vec(3'd3, 1, 5'd0,  32'hFFFF_FF00, 32'h8000_0001, 4'h3, 1, "R7");
        vec(3'd6, 1, 5'd0,  32'd9,         32'hDEAD_BEEF, 4'h3, 1, "R12");
        vec(3'd1, 0, 5'd1,  '0,            32'h0000_0001, 4'h9, 1, "R9");
        vec(3'd1, 0, 5'd3,  '0,            32'hFFFF_FFFF, 4'h5, 0, "R10");

        for (int k = 0; k < 600; k++) begin
            logic [2:0]  ro;
            logic [31:0] rc;
            ro = 3'($urandom_range(0, 7));
            rc = $urandom;
            if (k % 3 == 0) rc[7:0] = 8'($urandom_range(28, 68));
            vec(ro, bit'($urandom_range(0, 1)), 5'($urandom), rc, $urandom,
                4'($urandom), bit'($urandom_range(0, 3) != 0), op_tag(ro));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule